// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places incoming Ethernet frames into a circular region of local packet memory. The region is cut into 256-byte pages and framed by a first-page register and a limit-page register; the page number shifted left by eight gives the byte address. A current-page pointer owned by the block marks where the next frame goes. A boundary page, advanced by the host as it drains frames, tells the block how much of the ring is still free. Each stored frame sits behind a 4-byte link header that gives the status, the page the following frame will start on, and the stored length. The host uses this header to walk the ring.

Frames arrive as a byte stream with start-of-frame and end-of-frame markers. The frame body is written first, one byte per cycle, from offset 4 of the current page onward. Short frames are then padded with zeros, and the header is written last, once the length is known. After the header the current page moves on and a sticky receive flag is raised. If there is not enough room, or the controller is halted, the frame is discarded as a whole and a one-cycle overflow pulse is given.

Top module: `rxring_writer`

## Requirements
- R1: After reset `cur_pg` is 0, `busy`, `ovf`, `rx_flag` and `mem_we` are 0, and `s_ready` is 1.
- R2: An accepted frame's byte i (i counting from 0 at the start-of-frame byte) is written one byte per cycle in arrival order, starting at byte address `cur_pg`*256+4.
- R3: A frame of fewer than 60 bytes is followed by zero bytes until 60 body bytes are stored; a frame of 60 or more bytes gets no padding.
- R4: The header goes at `cur_pg`*256 + 0..3. Byte 0 is status 0x01 (bit 0 = received OK). Byte 1 is the next page. Bytes 2 and 3 hold the stored body length plus 4, low byte first.
- R5: The next page is `cur_pg` + floor((L+4+4+255)/256), where L is the stored body length; when that value is at or above `stop_pg`, (`stop_pg`-`start_pg`) is subtracted.
- R6: A body byte whose address would reach `stop_pg`*256 is written at `start_pg`*256 instead, and writing continues upward from there.
- R7: Free space is (`bnd_pg`-`cur_pg`)*256 when `cur_pg` < `bnd_pg`, else ((`stop_pg`-`start_pg`)-(`cur_pg`-`bnd_pg`))*256. A frame whose start finds free space below MAX_FRAME+4 is dropped: nothing is written, `cur_pg` is unchanged, and `ovf` is high for exactly the one cycle after the start byte.
- R8: A frame whose start byte arrives while `halt` is 1 is dropped in the same way as in R7.
- R9: When the last header byte is written, `cur_pg` takes the next page and `rx_flag` becomes 1. `rx_flag` stays 1 until `rx_clr` is pulsed with no header completing in that cycle.
- R10: Body bytes beyond MAX_FRAME are not written, and the stored length is capped at MAX_FRAME.
- R11: `busy` is 1 from the cycle after an accepted start byte until the header is done. `s_ready` is 0 only while padding or header bytes are written, and a memory write happens in each of those cycles.
- R12: A `cur_set` pulse while no frame is in progress loads `cur_val` into `cur_pg` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Controller stopped; new frames are dropped |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | Page just past the end of the ring |
| bnd_pg | input | PG_W | Host boundary page |
| cur_set | input | 1 | Load `cur_val` into the current page |
| cur_val | input | PG_W | Value for `cur_set` |
| rx_clr | input | 1 | Clears the receive flag |
| s_valid | input | 1 | Stream byte valid |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream can take a byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | PG_W | Current write page |
| busy | output | 1 | A frame is being written |
| ovf | output | 1 | One-cycle drop pulse |
| rx_flag | output | 1 | Sticky receive-complete flag |

## Verification
The bench builds the block with an 8-bit page number and MAX_FRAME lowered to 300. With these values the drop threshold of 304 bytes lies between one page and two pages of free space, so a single page of headroom is enough to force a drop. A 310-byte frame can then exercise truncation, and a 280-byte frame placed on the last ring page of a six-page ring (pages 4 to 9) is enough to cross the wrap. The lowered MAX_FRAME also keeps the bench memory model down to 4 KiB.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int MIN_BODY = 60;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] STATUS_OK = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RECV = 3'd1,
    ST_SKIP = 3'd2,
    ST_PAD  = 3'd3,
    ST_HDR  = 3'd4
  } wr_state_e;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PG_W = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic [PG_W-1:0] cur_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  output logic            room_ok
);
  localparam int FW = PG_W + 9;
  localparam logic [FW-1:0] NEED_B = FW'(MAX_FRAME + rxr_pkg::HDR_BYTES);

  logic [PG_W:0] ring_pg;
  logic [PG_W:0] free_pg;

  always_comb begin
    ring_pg = {1'b0, stop_pg} - {1'b0, start_pg};
    if (cur_pg < bnd_pg) free_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
    else                 free_pg = ring_pg - ({1'b0, cur_pg} - {1'b0, bnd_pg});
    room_ok = ({free_pg, 8'h00} >= NEED_B);
  end
endmodule

// File: rtl/rxr_link.sv
module rxr_link #(
  parameter int PG_W = 8,
  parameter int LEN_W = 16
) (
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [LEN_W-1:0] body_len,
  output logic [PG_W-1:0]  next_pg,
  output logic [LEN_W-1:0] tot_len
);
  localparam int ROUND = 2 * rxr_pkg::HDR_BYTES + 255;

  logic [LEN_W:0] span;
  logic [PG_W:0]  raw;

  always_comb begin
    tot_len = body_len + LEN_W'(rxr_pkg::HDR_BYTES);
    span    = ({1'b0, body_len} + (LEN_W+1)'(ROUND)) >> 8;
    raw     = {1'b0, cur_pg} + (PG_W+1)'(span);
    if (raw >= {1'b0, stop_pg}) next_pg = PG_W'(raw - {1'b0, stop_pg} + {1'b0, start_pg});
    else                        next_pg = PG_W'(raw);
  end
endmodule

// File: rtl/rxr_step.sv
module rxr_step #(
  parameter int PG_W = 8
) (
  input  logic [PG_W+7:0] addr,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  output logic [PG_W+7:0] addr_nxt
);
  logic [PG_W+7:0] inc;

  always_comb begin
    inc = addr + 1'b1;
    addr_nxt = (inc == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : inc;
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int PG_W = 8,
  parameter int LEN_W = 16,
  parameter int MAX_FRAME = 1514
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic            cur_set,
  input  logic [PG_W-1:0] cur_val,
  input  logic            rx_clr,
  input  logic            s_valid,
  input  logic            s_sof,
  input  logic            s_eof,
  input  logic [7:0]      s_data,
  output logic            s_ready,
  output logic            mem_we,
  output logic [PG_W+7:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [PG_W-1:0] cur_pg,
  output logic            busy,
  output logic            ovf,
  output logic            rx_flag
);
  import rxr_pkg::*;

  localparam int AW = PG_W + 8;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_BODY);

  wr_state_e       st_q, st_d;
  logic [AW-1:0]   wptr_q, wptr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]      hidx_q, hidx_d;
  logic [PG_W-1:0] cur_q, cur_d;
  logic            flag_q, flag_d;
  logic            ovf_q, ovf_d;

  logic            room_ok;
  logic [PG_W-1:0] next_pg;
  logic [LEN_W-1:0] tot_len;
  logic [AW-1:0]   addr_nxt;

  rxr_space #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .cur_pg(cur_q), .bnd_pg(bnd_pg), .start_pg(start_pg), .stop_pg(stop_pg),
    .room_ok(room_ok)
  );

  rxr_link #(.PG_W(PG_W), .LEN_W(LEN_W)) u_link (
    .cur_pg(cur_q), .start_pg(start_pg), .stop_pg(stop_pg), .body_len(len_q),
    .next_pg(next_pg), .tot_len(tot_len)
  );

  rxr_step #(.PG_W(PG_W)) u_step (
    .addr(mem_addr), .start_pg(start_pg), .stop_pg(stop_pg), .addr_nxt(addr_nxt)
  );

  // next-state process
  always_comb begin
    st_d      = st_q;
    wptr_d    = wptr_q;
    len_d     = len_q;
    hidx_d    = hidx_q;
    cur_d     = cur_q;
    flag_d    = flag_q & ~rx_clr;
    ovf_d     = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = wptr_q;
    mem_wdata = s_data;
    unique case (st_q)
      ST_IDLE: begin
        if (cur_set) cur_d = cur_val;
        if (s_valid && s_sof) begin
          if (halt || !room_ok) begin
            ovf_d = 1'b1;
            if (!s_eof) st_d = ST_SKIP;
          end else begin
            mem_we   = 1'b1;
            mem_addr = {cur_q, 8'd4};
            wptr_d   = addr_nxt;
            len_d    = LEN_W'(1);
            if (s_eof) st_d = (LEN_W'(1) < MIN_L) ? ST_PAD : ST_HDR;
            else       st_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (s_valid) begin
          if (len_q < MAX_L) begin
            mem_we = 1'b1;
            wptr_d = addr_nxt;
            len_d  = len_q + 1'b1;
          end
          if (s_eof) st_d = (len_d < MIN_L) ? ST_PAD : ST_HDR;
        end
      end
      ST_SKIP: begin
        if (s_valid && s_eof) st_d = ST_IDLE;
      end
      ST_PAD: begin
        mem_we    = 1'b1;
        mem_wdata = 8'h00;
        wptr_d    = addr_nxt;
        len_d     = len_q + 1'b1;
        if (len_d >= MIN_L) st_d = ST_HDR;
      end
      ST_HDR: begin
        mem_we   = 1'b1;
        mem_addr = {cur_q, 6'd0, hidx_q};
        unique case (hidx_q)
          2'd0: mem_wdata = STATUS_OK;
          2'd1: mem_wdata = 8'(next_pg);
          2'd2: mem_wdata = tot_len[7:0];
          default: mem_wdata = 8'(tot_len >> 8);
        endcase
        hidx_d = hidx_q + 1'b1;
        if (hidx_q == 2'd3) begin
          cur_d  = next_pg;
          flag_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wptr_q <= '0;
      len_q  <= '0;
      hidx_q <= '0;
      cur_q  <= '0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wptr_q <= wptr_d;
      len_q  <= len_d;
      hidx_q <= hidx_d;
      cur_q  <= cur_d;
      flag_q <= flag_d;
      ovf_q  <= ovf_d;
    end
  end

  assign s_ready = (st_q != ST_PAD) && (st_q != ST_HDR);
  assign busy    = (st_q == ST_RECV) || (st_q == ST_PAD) || (st_q == ST_HDR);
  assign cur_pg  = cur_q;
  assign ovf     = ovf_q;
  assign rx_flag = flag_q;
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
  parameter int PG_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ovf,
  input logic [PG_W-1:0] cur_pg,
  input logic            cur_set,
  input logic            rx_flag,
  input logic            mem_we,
  input logic [PG_W+7:0] mem_addr,
  input logic            busy,
  input logic            s_ready,
  input logic [PG_W-1:0] start_pg,
  input logic [PG_W-1:0] stop_pg
);
  p_ovf_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  p_drop_keeps_cur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cur_pg == $past(cur_pg)));

  p_flag_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(mem_we));

  p_fill_writes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (mem_we && busy));

  p_addr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (start_pg < stop_pg)) |->
      ((mem_addr[PG_W+7:8] >= start_pg) && (mem_addr[PG_W+7:8] < stop_pg)));

  p_cur_moves_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pg != $past(cur_pg)) |-> ($past(cur_set) || $past(mem_we)));
endmodule

bind rxring_writer rxring_writer_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf(ovf), .cur_pg(cur_pg), .cur_set(cur_set),
  .rx_flag(rx_flag), .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy),
  .s_ready(s_ready), .start_pg(start_pg), .stop_pg(stop_pg)
);

// File: tb/sim_rxring_writer.sv
module sim_rxring_writer;
  localparam int PG_W = 8;
  localparam int MAXF = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic halt;
  logic [7:0] start_pg, stop_pg, bnd_pg, cur_val;
  logic cur_set, rx_clr, s_valid, s_sof, s_eof;
  logic [7:0] s_data;
  logic s_ready, mem_we, busy, ovf, rx_flag;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_pg;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rdy_lo = 0;
  int busy_hi = 0;
  int ovf_hi = 0;
  logic ovf_first;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  rxring_writer #(.PG_W(PG_W), .MAX_FRAME(MAXF)) u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_set(cur_set), .cur_val(cur_val), .rx_clr(rx_clr),
    .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof), .s_data(s_data),
    .s_ready(s_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_pg(cur_pg), .busy(busy), .ovf(ovf), .rx_flag(rx_flag)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!s_ready) rdy_lo <= rdy_lo + 1;
    if (busy) busy_hi <= busy_hi + 1;
    if (ovf) ovf_hi <= ovf_hi + 1;
  end

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'(seed + 3 * i);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_counters;
    @(negedge clk);
    wr_cnt = 0; rdy_lo = 0; busy_hi = 0; ovf_hi = 0;
  endtask

  task automatic send_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) ovf_first = ovf;
      s_valid = 1'b1;
      s_sof   = (i == 0);
      s_eof   = (i == n - 1);
      s_data  = dbyte(seed, i);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  task automatic load_cur(input logic [7:0] v);
    @(negedge clk); cur_set = 1'b1; cur_val = v;
    @(negedge clk); cur_set = 1'b0;
    check("R12 cur_pg after cur_set", cur_pg, v);
  endtask

  task automatic t_reset;
    check("R1 cur_pg", cur_pg, 0);
    check("R1 busy", busy, 0);
    check("R1 ovf", ovf, 0);
    check("R1 rx_flag", rx_flag, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 s_ready", s_ready, 1);
  endtask

  task automatic t_short;
    load_cur(8'd4); bnd_pg = 8'd4;
    clear_counters();
    send_frame(10, 16);
    check("R7 no ovf on accept", ovf_first, 0);
    check("R2 first byte", mem[12'h404], dbyte(16, 0));
    check("R2 last byte", mem[12'h40D], dbyte(16, 9));
    check("R3 first pad", mem[12'h40E], 0);
    check("R3 last pad", mem[12'h43F], 0);
    check("R4 status", mem[12'h400], 8'h01);
    check("R4 R5 next page", mem[12'h401], 5);
    check("R4 len lo", mem[12'h402], 8'h40);
    check("R4 len hi", mem[12'h403], 8'h00);
    check("R9 cur_pg", cur_pg, 5);
    check("R9 rx_flag", rx_flag, 1);
    check("R3 write count", wr_cnt, 64);
    check("R11 ready low cycles", rdy_lo, 54);
    check("R11 busy cycles", busy_hi, 63);
  endtask

  task automatic t_flag_clear;
    @(negedge clk); rx_clr = 1'b1;
    @(negedge clk); rx_clr = 1'b0;
    check("R9 rx_flag cleared", rx_flag, 0);
  endtask

  task automatic t_max;
    clear_counters();
    send_frame(300, 7);
    check("R2 first byte max", mem[12'h504], dbyte(7, 0));
    check("R2 last byte max", mem[12'h62F], dbyte(7, 299));
    check("R5 next page two", mem[12'h501], 7);
    check("R4 len lo 304", mem[12'h502], 8'h30);
    check("R4 len hi 304", mem[12'h503], 8'h01);
    check("R9 cur_pg max", cur_pg, 7);
    check("R3 no pad writes", wr_cnt, 304);
  endtask

  task automatic t_wrap;
    load_cur(8'd9); bnd_pg = 8'd8;
    clear_counters();
    send_frame(280, 40);
    check("R6 last before wrap", mem[12'h9FF], dbyte(40, 251));
    check("R6 first after wrap", mem[12'h400], dbyte(40, 252));
    check("R6 last after wrap", mem[12'h41B], dbyte(40, 279));
    check("R5 wrapped next page", mem[12'h901], 5);
    check("R4 len lo 284", mem[12'h902], 8'h1C);
    check("R4 len hi 284", mem[12'h903], 8'h01);
    check("R9 cur_pg wrap", cur_pg, 5);
  endtask

  task automatic t_exact60;
    bnd_pg = 8'd4;
    clear_counters();
    send_frame(60, 90);
    check("R3 last byte 60", mem[12'h53F], dbyte(90, 59));
    check("R4 len lo 64", mem[12'h502], 8'h40);
    check("R3 no pad 60", wr_cnt, 64);
    check("R11 ready low header only", rdy_lo, 4);
    check("R9 cur_pg 60", cur_pg, 6);
  endtask

  task automatic t_oversize;
    clear_counters();
    send_frame(310, 1);
    check("R10 last kept", mem[12'h72F], dbyte(1, 299));
    check("R10 untouched past max", mem[12'h730], 8'hEE);
    check("R10 len lo", mem[12'h602], 8'h30);
    check("R10 len hi", mem[12'h603], 8'h01);
    check("R10 write count", wr_cnt, 304);
    check("R10 cur_pg", cur_pg, 8);
  endtask

  task automatic t_drop_space;
    bnd_pg = 8'd9;
    mem[12'h804] = 8'hEE;
    clear_counters();
    send_frame(20, 5);
    check("R7 ovf after sof", ovf_first, 1);
    check("R7 ovf one cycle", ovf_hi, 1);
    check("R7 no writes", wr_cnt, 0);
    check("R7 memory untouched", mem[12'h804], 8'hEE);
    check("R7 cur_pg kept", cur_pg, 8);
    check("R7 busy never", busy_hi, 0);
  endtask

  task automatic t_drop_halt;
    bnd_pg = 8'd8; halt = 1'b1;
    clear_counters();
    send_frame(20, 5);
    check("R8 ovf after sof", ovf_first, 1);
    check("R8 ovf one cycle", ovf_hi, 1);
    check("R8 no writes", wr_cnt, 0);
    check("R8 cur_pg kept", cur_pg, 8);
    halt = 1'b0;
    clear_counters();
    send_frame(20, 5);
    check("R8 accepted after halt", wr_cnt, 64);
    check("R8 R5 cur_pg after", cur_pg, 9);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
    rst_n = 1'b0; halt = 1'b0; start_pg = 8'd4; stop_pg = 8'd10; bnd_pg = 8'd4;
    cur_set = 1'b0; cur_val = 8'd0; rx_clr = 1'b0;
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_data = 8'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_short();
    t_flag_clear();
    t_max();
    t_wrap();
    t_exact60();
    t_oversize();
    t_drop_space();
    t_drop_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule